// File: doc/BRIEF.md
# Prioritized Interrupt Sequencer

This block decides, in every opcode-fetch cycle of a processor core, whether the core should begin a reset sequence, a non-maskable interrupt sequence or a maskable interrupt sequence instead of fetching its next opcode. It holds the pending state of each request source. It timestamps each request against a free-running cycle counter supplied by the core. When a request wins, it presents a single-cycle take indication together with the vector address and the sequencer state code that the core loads next.

Reset requests are latched and win without any latency. The non-maskable line is edge-captured: one rising edge gives one service, however long the line stays high. The two maskable sources, video and timer, are merged into one level-sensitive request. That request is gated by the core's interrupt-disable flag. Both interrupt kinds must have been pending for a minimum number of cycles before they are accepted. Outside fetch cycles nothing is taken, and all pending state is kept.

Top module: `intSeq`

## Requirements
- R1: After reset is released and with no request active, no take output is high, and `vector` and `nextState` are both 0x0000.
- R2: A take is issued only in a cycle where `fetchCycle` is high. Requests that arrive while it is low stay pending and are taken in the first fetch cycle once they qualify.
- R3: Priority is fixed as reset, then non-maskable, then maskable, and at most one take output is high in any cycle.
- R4: A non-maskable or maskable request is accepted only when `cycleCount` minus the counter value of the cycle in which that request rose is at least LATENCY (default 2). With the default, a request that rises in cycle n with `fetchCycle` high is taken in cycle n+2.
- R5: The non-maskable line is edge-sensitive. A low-to-high change latches a pending request, and taking it clears the latch. A line held high is taken once only, and a new service needs the line to go low and rise again.
- R6: The maskable request is the OR of `irqVideo` and `irqTimer`. It is taken only while `iFlag` is 0 (1 means masked). It is level-sensitive, so a request that falls before acceptance is never taken.
- R7: The outputs for each take are as follows. Reset gives vector 0xFFFC and nextState 0x0000. Non-maskable gives vector 0xFFFA and nextState 0x0010. Maskable gives vector 0xFFFE and nextState 0x0008. With no take, both outputs are 0x0000.
- R8: A `resetReq` pulse in cycle r is taken in the first fetch cycle from r+1 onward, with no latency qualification. Taking it discards the pending non-maskable latch and the recorded line states. A maskable line still high afterwards is therefore timed again from the cycle after the reset take.
- R9: Latency arithmetic is modulo 2^CW, so a request timestamped just before the counter wraps is taken on schedule after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetReq | input | 1 | Processor reset request, latched until taken |
| nmiLine | input | 1 | Non-maskable interrupt line, active high |
| irqVideo | input | 1 | Maskable request from the video source, level |
| irqTimer | input | 1 | Maskable request from the timer source, level |
| iFlag | input | 1 | Interrupt-disable flag; 1 masks maskable requests |
| fetchCycle | input | 1 | High in the opcode-fetch cycle (sequencer state 0) |
| cycleCount | input | CW | Free-running cycle counter |
| takeReset | output | 1 | Reset sequence starts this cycle |
| takeNmi | output | 1 | Non-maskable sequence starts this cycle |
| takeIrq | output | 1 | Maskable sequence starts this cycle |
| nextState | output | 16 | Sequencer state to load: opcode in the upper byte, cycle number in the lower |
| vector | output | 16 | Address of the vector for the sequence taken |

## Verification
The bound checker tests several properties on every cycle. Takes are mutually exclusive and confined to fetch cycles. Each take carries its own vector and state code. A maskable take only happens with the mask clear and the merged line high for the two preceding cycles. Two non-maskable takes never come back to back, and none directly follows a reset take. The bench scenarios cover the behaviour that only a timeline can show: the exact cycle of each acceptance, a held line giving one service, and a request parked across non-fetch cycles. They also cover a maskable request that falls away unserved, the discarding of pending work by a reset, and counter wrap-around.

// File: rtl/intSeq_pkg.sv
package intSeq_pkg;

  localparam int STATE_W = 16;

  typedef struct packed {
    logic rst;
    logic nmi;
    logic irq;
  } takeStrobes_t;

  localparam logic [STATE_W-1:0] VEC_RESET = 16'hFFFC;
  localparam logic [STATE_W-1:0] VEC_NMI   = 16'hFFFA;
  localparam logic [STATE_W-1:0] VEC_IRQ   = 16'hFFFE;

  localparam logic [STATE_W-1:0] ST_FETCH  = 16'h0000;
  localparam logic [STATE_W-1:0] ST_NMI    = 16'h0010;
  localparam logic [STATE_W-1:0] ST_IRQ    = 16'h0008;

  localparam int SRC_NMI = 0;
  localparam int SRC_IRQ = 1;
  localparam int NSRC    = 2;

endpackage

// File: rtl/intAge.sv
module intAge #(
  parameter int CW      = 32,
  parameter int LATENCY = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          capture,
  input  logic [CW-1:0] cycleCount,
  output logic          aged
);
  localparam logic [CW-1:0] LAT_W = CW'(LATENCY);

  logic [CW-1:0] stamp;
  logic [CW-1:0] elapsed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        stamp <= '0;
    else if (capture) stamp <= cycleCount;
  end

  // modulo difference keeps the window correct across a counter wrap
  assign elapsed = cycleCount - stamp;
  assign aged    = (elapsed >= LAT_W);
endmodule

// File: rtl/intPath.sv
module intPath
  import intSeq_pkg::*;
#(
  parameter int CW      = 32,
  parameter int LATENCY = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic               nmiLine,
  input  logic               irqLine,
  input  logic [CW-1:0]      cycleCount,
  input  takeStrobes_t       take,
  output logic               resetPend,
  output logic               nmiReady,
  output logic               irqReady,
  output logic [STATE_W-1:0] vector,
  output logic [STATE_W-1:0] nextState
);
  logic nmiPrev, nmiPend, irqPrev, rstPendQ;
  logic nmiRise, irqRise;
  logic [NSRC-1:0] capture;
  logic [NSRC-1:0] aged;

  assign nmiRise = nmiLine & ~nmiPrev;
  assign irqRise = irqLine & ~irqPrev;

  // a fresh edge is timed only when no older one is still waiting
  assign capture[SRC_NMI] = nmiRise & (~nmiPend | take.nmi) & ~take.rst;
  assign capture[SRC_IRQ] = irqRise & ~take.rst;

  for (genvar s = 0; s < NSRC; s++) begin : g_age
    intAge #(.CW(CW), .LATENCY(LATENCY)) u_age (
      .clk       (clk),
      .rstN      (rstN),
      .capture   (capture[s]),
      .cycleCount(cycleCount),
      .aged      (aged[s])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPendQ <= 1'b0;
      nmiPrev  <= 1'b0;
      nmiPend  <= 1'b0;
      irqPrev  <= 1'b0;
    end else if (take.rst) begin
      rstPendQ <= resetReq;
      nmiPrev  <= 1'b0;
      nmiPend  <= 1'b0;
      irqPrev  <= 1'b0;
    end else begin
      rstPendQ <= rstPendQ | resetReq;
      nmiPrev  <= nmiLine;
      irqPrev  <= irqLine;
      if (capture[SRC_NMI])  nmiPend <= 1'b1;
      else if (take.nmi)     nmiPend <= 1'b0;
    end
  end

  assign resetPend = rstPendQ;
  assign nmiReady  = nmiPend & aged[SRC_NMI];
  assign irqReady  = irqLine & irqPrev & aged[SRC_IRQ];

  always_comb begin
    vector    = '0;
    nextState = ST_FETCH;
    if (take.rst) begin
      vector = VEC_RESET;
    end else if (take.nmi) begin
      vector    = VEC_NMI;
      nextState = ST_NMI;
    end else if (take.irq) begin
      vector    = VEC_IRQ;
      nextState = ST_IRQ;
    end
  end
endmodule

// File: rtl/intCtrl.sv
module intCtrl
  import intSeq_pkg::*;
(
  input  logic         fetchCycle,
  input  logic         iFlag,
  input  logic         resetPend,
  input  logic         nmiReady,
  input  logic         irqReady,
  output takeStrobes_t take
);
  always_comb begin
    take = '0;
    if (fetchCycle) begin
      if (resetPend)            take.rst = 1'b1;
      else if (nmiReady)        take.nmi = 1'b1;
      else if (irqReady && !iFlag) take.irq = 1'b1;
    end
  end
endmodule

// File: rtl/intSeq.sv
module intSeq
  import intSeq_pkg::*;
#(
  parameter int CW      = 32,
  parameter int LATENCY = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic               nmiLine,
  input  logic               irqVideo,
  input  logic               irqTimer,
  input  logic               iFlag,
  input  logic               fetchCycle,
  input  logic [CW-1:0]      cycleCount,
  output logic               takeReset,
  output logic               takeNmi,
  output logic               takeIrq,
  output logic [STATE_W-1:0] nextState,
  output logic [STATE_W-1:0] vector
);
  takeStrobes_t take;
  logic resetPend, nmiReady, irqReady;
  logic irqLine;

  assign irqLine = irqVideo | irqTimer;

  intCtrl u_ctrl (
    .fetchCycle(fetchCycle),
    .iFlag     (iFlag),
    .resetPend (resetPend),
    .nmiReady  (nmiReady),
    .irqReady  (irqReady),
    .take      (take)
  );

  intPath #(.CW(CW), .LATENCY(LATENCY)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .resetReq  (resetReq),
    .nmiLine   (nmiLine),
    .irqLine   (irqLine),
    .cycleCount(cycleCount),
    .take      (take),
    .resetPend (resetPend),
    .nmiReady  (nmiReady),
    .irqReady  (irqReady),
    .vector    (vector),
    .nextState (nextState)
  );

  assign takeReset = take.rst;
  assign takeNmi   = take.nmi;
  assign takeIrq   = take.irq;
endmodule

// File: rtl/intSeqChk.sv
module intSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        nmiLine,
  input logic        irqVideo,
  input logic        irqTimer,
  input logic        iFlag,
  input logic        fetchCycle,
  input logic        takeReset,
  input logic        takeNmi,
  input logic        takeIrq,
  input logic [15:0] nextState,
  input logic [15:0] vector
);
  // R3
  one_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({takeReset, takeNmi, takeIrq}));

  // R2
  fetch_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeReset || takeNmi || takeIrq) |-> fetchCycle);

  // R7
  nmi_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeNmi |-> (vector == 16'hFFFA && nextState == 16'h0010));

  // R7
  irq_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (vector == 16'hFFFE && nextState == 16'h0008));

  // R7
  rst_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeReset |-> (vector == 16'hFFFC && nextState == 16'h0000));

  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (!iFlag && (irqVideo || irqTimer)));

  // R4
  irq_age_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> ($past(irqVideo || irqTimer, 1) && $past(irqVideo || irqTimer, 2)));

  // R5
  nmi_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeNmi |=> !takeNmi);

  // R8
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeReset |=> !takeNmi);

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(takeReset || takeNmi || takeIrq) |-> (vector == 16'h0000 && nextState == 16'h0000));

  logic unusedLine;
  assign unusedLine = nmiLine;
endmodule

bind intSeq intSeqChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .nmiLine   (nmiLine),
  .irqVideo  (irqVideo),
  .irqTimer  (irqTimer),
  .iFlag     (iFlag),
  .fetchCycle(fetchCycle),
  .takeReset (takeReset),
  .takeNmi   (takeNmi),
  .takeIrq   (takeIrq),
  .nextState (nextState),
  .vector    (vector)
);

// File: tb/intSeq_bench.sv
`timescale 1ns/1ps
module intSeq_bench;
  localparam int CW = 32;
  localparam int KIND_RST = 1, KIND_NMI = 2, KIND_IRQ = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetReq = 0, nmiLine = 0, irqVideo = 0, irqTimer = 0, iFlag = 0, fetchCycle = 0;
  logic [CW-1:0] cnt = '0;
  logic takeReset, takeNmi, takeIrq;
  logic [15:0] nextState, vector;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] cyc;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  always #4 clk = ~clk;

  intSeq #(.CW(CW)) u_intSeq (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiLine(nmiLine),
    .irqVideo(irqVideo), .irqTimer(irqTimer), .iFlag(iFlag),
    .fetchCycle(fetchCycle), .cycleCount(cnt),
    .takeReset(takeReset), .takeNmi(takeNmi), .takeIrq(takeIrq),
    .nextState(nextState), .vector(vector)
  );

  function automatic logic [15:0] expVec(int k);
    case (k)
      KIND_RST: return 16'hFFFC;
      KIND_NMI: return 16'hFFFA;
      KIND_IRQ: return 16'hFFFE;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] expState(int k);
    case (k)
      KIND_NMI: return 16'h0010;
      KIND_IRQ: return 16'h0008;
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    cnt = cnt + 1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expectTake(int kind, logic [31:0] cyc, string tag);
    expItem_t it;
    it.kind = kind;
    it.cyc  = cyc;
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic expectIdle(string tag);
    #2;
    total++;
    if (takeReset || takeNmi || takeIrq || vector != 16'h0 || nextState != 16'h0) begin
      bad++;
      $display("FAIL %s idle: takes=%b%b%b vec=%h st=%h expected takes=000 vec=0000 st=0000",
               tag, takeReset, takeNmi, takeIrq, vector, nextState);
    end
  endtask

  // monitor: pops an expected item for every take the design presents
  always @(negedge clk) begin
    if (rstN && (takeReset || takeNmi || takeIrq)) begin
      int kind;
      expItem_t it;
      kind = (takeReset ? KIND_RST : 0) + (takeNmi ? KIND_NMI : 0) + (takeIrq ? KIND_IRQ : 0);
      if ($countones({takeReset, takeNmi, takeIrq}) > 1) kind = 7;
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected take kind=%0d at cycle %0d, expected none", kind, cnt);
      end else begin
        it = sbq.pop_front();
        if (kind != it.kind || cnt != it.cyc || vector != expVec(it.kind) ||
            nextState != expState(it.kind)) begin
          bad++;
          $display("FAIL %s take kind=%0d cyc=%0d vec=%h st=%h expected kind=%0d cyc=%0d vec=%h st=%h",
                   it.tag, kind, cnt, vector, nextState, it.kind, it.cyc,
                   expVec(it.kind), expState(it.kind));
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] n;
    ticks(3);
    rstN = 1'b1;

    // R1: quiet after reset
    fetchCycle = 1;
    expectIdle("R1");
    tick(); expectIdle("R1");
    tick(); expectIdle("R1");

    // R4 R5 R7: edge on the line, taken two cycles later, once only
    tick(); n = cnt; nmiLine = 1;
    expectTake(KIND_NMI, n + 2, "R4");
    tick(); expectIdle("R4");
    ticks(5);
    nmiLine = 0;
    tick(); n = cnt; nmiLine = 1;
    expectTake(KIND_NMI, n + 2, "R5");
    ticks(3);
    nmiLine = 0;
    tick();

    // R2: parked while no fetch cycle
    fetchCycle = 0; nmiLine = 1;
    tick(); nmiLine = 0;
    ticks(4); expectIdle("R2");
    tick(); fetchCycle = 1;
    expectTake(KIND_NMI, cnt, "R2");
    tick(); fetchCycle = 0;

    // R6: masked video request, taken when the mask clears
    tick(); iFlag = 1; fetchCycle = 1; irqVideo = 1;
    ticks(4); expectIdle("R6");
    tick(); iFlag = 0;
    expectTake(KIND_IRQ, cnt, "R6");
    tick(); fetchCycle = 0; irqVideo = 0;
    tick();

    // R4 R6: timer request latency
    fetchCycle = 1; irqTimer = 1; n = cnt;
    expectTake(KIND_IRQ, n + 2, "R4");
    tick(); expectIdle("R4");
    tick();
    tick(); fetchCycle = 0; irqTimer = 0;
    tick();

    // R6: request that falls before acceptance is lost
    irqVideo = 1;
    tick(); irqVideo = 0;
    tick(); fetchCycle = 1;
    tick(); expectIdle("R6");
    tick(); expectIdle("R6");
    tick(); fetchCycle = 0;

    // R3: both kinds qualified, non-maskable first then maskable
    tick(); nmiLine = 1; irqTimer = 1;
    ticks(3); fetchCycle = 1;
    expectTake(KIND_NMI, cnt, "R3");
    expectTake(KIND_IRQ, cnt + 1, "R3");
    tick();
    tick(); fetchCycle = 0; irqTimer = 0; nmiLine = 0;
    tick();

    // R8: reset wins and discards pending work; held irq is retimed
    nmiLine = 1; irqVideo = 1;
    tick(); resetReq = 1;
    tick(); resetReq = 0; nmiLine = 0;
    ticks(2); fetchCycle = 1; n = cnt;
    expectTake(KIND_RST, n, "R8");
    expectTake(KIND_IRQ, n + 3, "R8");
    tick(); expectIdle("R8");
    tick(); expectIdle("R8");
    tick();
    tick(); fetchCycle = 0; irqVideo = 0;
    ticks(2);

    // R8: reset pulse with fetch high, taken next cycle
    fetchCycle = 1; resetReq = 1;
    expectTake(KIND_RST, cnt + 1, "R8");
    tick(); resetReq = 0;
    tick(); expectIdle("R8");

    // R9: counter wrap
    tick(); cnt = 32'hFFFF_FFFE; nmiLine = 1;
    expectTake(KIND_NMI, 32'h0000_0000, "R9");
    ticks(3); nmiLine = 0;
    ticks(3);

    total++;
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL %s missing take, actual=none expected kind=%0d cyc=%0d",
               sbq[0].tag, sbq[0].kind, sbq[0].cyc);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule